// File: doc/BRIEF.md
# Three-Wire Register Serial Master

This block turns single register requests from a host into transactions on a three-wire serial bus. The bus has an active-low select, a serial clock and one shared data line. The data line's pad is split into an output value, an output enable and an input, so the tristate buffer sits outside the block. The host presents a read/write flag, a 7-bit register address and a 16-bit write value together with a one-cycle `start`. While the transfer runs, the block holds `busy` high. At the end it pulses `done` for one cycle; for a read, `rdata` then holds the returned word.

Every frame begins with a padding bit that the target discards, followed by a direction bit (0 = write, 1 = read) and the address. A write then carries the 16-bit value in the same frame. A read stops after its 9-bit header. It gives one extra clock pulse with nothing on the line, releases the line, and clocks in 16 bits from the target. The parameter `DIV` sets bit timing: every phase of the bus (pre-select wait, post-select wait, clock low, clock high, final wait) lasts `DIV` system clocks.

The controller has ten named states. `ST_IDLE` moves to `ST_LEAD` on start. `ST_LEAD` moves to `ST_SELECT`. `ST_SELECT` moves to `ST_BIT_LO`. `ST_BIT_LO` moves to `ST_BIT_HI`. `ST_BIT_HI` goes back to `ST_BIT_LO` while header or payload bits remain. After the last bit it goes to `ST_TURN_LO` for a read or to `ST_TRAIL` for a write. `ST_TURN_LO` moves to `ST_TURN_HI`, which moves to `ST_READ_LO`. `ST_READ_LO` moves to `ST_READ_HI`. `ST_READ_HI` goes back to `ST_READ_LO` until 16 bits are taken, then to `ST_TRAIL`. `ST_TRAIL` returns to `ST_IDLE` and raises `done`. Each transition out of a non-idle state happens when the half-bit timer expires.

Top module: `tw_reg_master`

## Requirements
- R1: After reset the bus is idle: `bus_en_n`=1, `bus_clk`=0, `bus_dout`=0, `bus_doe`=1; `busy`=0, `done`=0, `rdata`=0.
- R2: A write (`rw`=0) sends 25 bits MSB first: a 0 padding bit, a 0 direction bit, `addr[6:0]`, then `wdata[15:0]`. Each bit is placed on `bus_dout` while `bus_clk` is low and stays unchanged while `bus_clk` is high.
- R3: A read (`rw`=1) sends a 9-bit header MSB first: a 0 padding bit, a 1 direction bit, then `addr[6:0]`.
- R4: After a read header, exactly one more `bus_clk` pulse is given while `bus_doe`=1 and `bus_dout`=0.
- R5: After the turnaround pulse the block sets `bus_doe`=0 for 16 `bus_clk` pulses. It samples `bus_din` on the system clock edge where each pulse falls and assembles the word MSB first into `rdata`. `bus_doe` returns to 1 before `bus_en_n` rises, and `bus_doe` is never 0 while `bus_en_n` is high.
- R6: Every bus phase lasts `DIV` system clocks. From the edge that accepts `start`, `done` appears after 53·`DIV` cycles for a write and 55·`DIV` cycles for a read.
- R7: `bus_en_n` falls `DIV` cycles after `start` is accepted and rises `DIV` cycles after the last `bus_clk` falling edge. `bus_clk` is never high while `bus_en_n` is high.
- R8: `done` is high for exactly one cycle, with `busy` low in that cycle. A `start` that arrives while `busy` is high changes neither the frame in progress nor the number of `done` pulses.
- R9: `rdata` changes only when a read completes. A write leaves it at the last read result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 7 | Register address |
| wdata | input | 16 | Value to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the most recent read |
| bus_en_n | output | 1 | Active-low bus select |
| bus_clk | output | 1 | Serial clock |
| bus_dout | output | 1 | Value driven onto the data line |
| bus_doe | output | 1 | Data line output enable for the pad |
| bus_din | input | 1 | Value sensed on the data line |

## Verification
The bench builds the block with `DIV`=2. This keeps a write at 106 cycles and a read at 110, so every one of the 128 addresses gets both a write and a read within the run. Expected frames, cycle counts and read words are formed arithmetically from the address. A bus-side target model serves a per-address word, which covers every address bit pattern in both header formats and all-ones, all-zeros and mixed payloads. Extra runs inject a conflicting `start` mid-transfer and interleave reads with writes to show that `rdata` holds.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SELECT,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_TURN_LO,
        ST_TURN_HI,
        ST_READ_LO,
        ST_READ_HI,
        ST_TRAIL
    } tw_state_e;
endpackage

// File: rtl/tw_half_timer.sv
module tw_half_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST) else $error("timer out of range"); // R6
endmodule

// File: rtl/tw_frame_shift.sv
module tw_frame_shift #(
    parameter int TX_W = 25,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_val,
    input  logic            tx_adv,
    input  logic            rx_adv,
    input  logic            din,
    output logic            tx_bit,
    output logic [RX_W-1:0] rx_word
);
    logic [TX_W-1:0] tx_q;
    logic [RX_W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load)
            tx_q <= load_val;
        else if (tx_adv)
            tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_q <= '0;
        else if (rx_adv)
            rx_q <= {rx_q[RX_W-2:0], din};
    end

    assign tx_bit  = tx_q[TX_W-1];
    assign rx_word = rx_q;
endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master
    import tw_reg_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_en_n,
    output logic              bus_clk,
    output logic              bus_dout,
    output logic              bus_doe,
    input  logic              bus_din
);
    localparam int HDR_W = 2 + ADDR_W;
    localparam int TX_W  = HDR_W + DATA_W;
    localparam int BW    = $clog2(TX_W + 1);

    tw_state_e         state_q, state_d;
    logic [BW-1:0]     bits_q;
    logic              rw_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    logic              tick;
    logic              tx_bit;
    logic [DATA_W-1:0] rx_word;
    logic              load;
    logic [TX_W-1:0]   load_val;
    logic              tx_adv;
    logic              rx_adv;
    logic              last_bit;

    assign load     = (state_q == ST_IDLE) && start;
    assign load_val = rw ? {1'b0, 1'b1, addr, {DATA_W{1'b0}}}
                         : {1'b0, 1'b0, addr, wdata};
    assign tx_adv   = tick && (state_q == ST_BIT_HI);
    assign rx_adv   = tick && (state_q == ST_READ_HI);
    assign last_bit = (bits_q == BW'(1));

    tw_half_timer #(.DIV(DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    tw_frame_shift #(.TX_W(TX_W), .RX_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tx_adv   (tx_adv),
        .rx_adv   (rx_adv),
        .din      (bus_din),
        .tx_bit   (tx_bit),
        .rx_word  (rx_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_LEAD;
            ST_LEAD:    if (tick)  state_d = ST_SELECT;
            ST_SELECT:  if (tick)  state_d = ST_BIT_LO;
            ST_BIT_LO:  if (tick)  state_d = ST_BIT_HI;
            ST_BIT_HI:  if (tick)  state_d = !last_bit ? ST_BIT_LO
                                           : (rw_q ? ST_TURN_LO : ST_TRAIL);
            ST_TURN_LO: if (tick)  state_d = ST_TURN_HI;
            ST_TURN_HI: if (tick)  state_d = ST_READ_LO;
            ST_READ_LO: if (tick)  state_d = ST_READ_HI;
            ST_READ_HI: if (tick)  state_d = last_bit ? ST_TRAIL : ST_READ_LO;
            ST_TRAIL:   if (tick)  state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // bit counter, direction, completion and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q  <= '0;
            rw_q    <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                bits_q <= rw ? BW'(HDR_W) : BW'(TX_W);
                rw_q   <= rw;
            end else if (tick) begin
                unique case (state_q)
                    ST_BIT_HI:  bits_q <= last_bit ? BW'(DATA_W) : bits_q - 1'b1;
                    ST_READ_HI: bits_q <= bits_q - 1'b1;
                    ST_TRAIL: begin
                        done_q <= 1'b1;
                        if (rw_q) rdata_q <= rx_word;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = done_q;
        rdata    = rdata_q;
        bus_en_n = (state_q == ST_IDLE) || (state_q == ST_LEAD);
        bus_clk  = (state_q == ST_BIT_HI) || (state_q == ST_TURN_HI)
                || (state_q == ST_READ_HI);
        bus_doe  = !((state_q == ST_READ_LO) || (state_q == ST_READ_HI));
        bus_dout = ((state_q == ST_BIT_LO) || (state_q == ST_BIT_HI)) ? tx_bit : 1'b0;
    end

    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk |-> $stable(bus_dout)) else $error("data moved while clock high"); // R2
    AST_RELEASE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_doe |-> !bus_en_n) else $error("line released outside a frame"); // R5
    AST_CLK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_n |-> !bus_clk) else $error("clock while deselected"); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && bus_en_n)) else $error("done while active"); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(rw_q)) else $error("start taken while busy"); // R8
    AST_RDATA_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> (done && rw_q)) else $error("rdata moved without read"); // R9
endmodule

// File: tb/tw_reg_master_test.sv
module tw_reg_master_test;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rw_i = 1'b0;
    logic [6:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        bus_en_n, bus_clk, bus_dout, bus_doe;
    logic        bus_din = 1'b1;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    tw_reg_master #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rw(rw_i), .addr(addr_i),
        .wdata(wdata_i), .busy(busy), .done(done), .rdata(rdata),
        .bus_en_n(bus_en_n), .bus_clk(bus_clk), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din)
    );

    // bus-side monitor and target model
    logic        prev_clk = 1'b0, prev_en = 1'b1, prev_doe = 1'b1;
    int          tx_cnt = 0, rd_cnt = 0, sidx = 15, idle_clk = 0;
    logic [31:0] tx_cap = '0;
    logic [15:0] slave_word = '0;

    always @(negedge clk) begin
        if (prev_en && !bus_en_n) begin
            tx_cnt = 0; rd_cnt = 0; tx_cap = '0;
        end
        if (!prev_clk && bus_clk && !bus_en_n) begin
            if (bus_doe) begin
                tx_cap = {tx_cap[30:0], bus_dout};
                tx_cnt++;
            end else
                rd_cnt++;
        end
        if (bus_doe) sidx = 15;
        else if (!prev_doe && prev_clk && !bus_clk && sidx > 0) sidx--;
        bus_din = bus_doe ? 1'b1 : slave_word[sidx];
        if (bus_en_n && bus_clk) idle_clk++;
        prev_clk = bus_clk; prev_en = bus_en_n; prev_doe = bus_doe;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [15:0] last_read = '0;

    task automatic xfer(input bit rw, input logic [6:0] a, input logic [15:0] wd,
                        input bit inject);
        int cyc;
        int fall_at;
        @(negedge clk);
        start = 1'b1; rw_i = rw; addr_i = a; wdata_i = wd;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; fall_at = -1;
        while (!done && cyc < 2000) begin
            if (fall_at < 0 && !bus_en_n) fall_at = cyc;
            if (inject && cyc == 4) begin
                start = 1'b1; rw_i = ~rw; addr_i = ~a; wdata_i = ~wd;
            end else
                start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == (rw ? 55 : 53) * DIV, "R6", "cycles to done", cyc, (rw ? 55 : 53) * DIV);
        chk(fall_at == DIV, "R7", "select fall delay", fall_at, DIV);
        chk(!busy && bus_en_n, "R8", "idle at done", {busy, bus_en_n}, 2'b01);
        if (rw) begin
            chk(tx_cnt == 10, "R3", "driven pulses on read", tx_cnt, 10);
            chk(tx_cap[9:1] == {2'b01, a}, "R3", "read header", tx_cap[9:1], {2'b01, a});
            chk(tx_cap[0] == 1'b0, "R4", "turnaround bit", tx_cap[0], 0);
            chk(rd_cnt == 16, "R5", "readback pulses", rd_cnt, 16);
            chk(rdata == slave_word, "R5", "read word", rdata, slave_word);
            last_read = slave_word;
        end else begin
            chk(tx_cnt == 25, "R2", "write pulses", tx_cnt, 25);
            chk(tx_cap[24:0] == {2'b00, a, wd}, "R2", "write frame", tx_cap[24:0], {2'b00, a, wd});
            chk(rd_cnt == 0, "R2", "no readback on write", rd_cnt, 0);
            chk(rdata == last_read, "R9", "rdata held over write", rdata, last_read);
        end
        @(negedge clk);
        chk(!done, "R8", "done one cycle", done, 0);
        chk(!busy, "R8", "no extra transfer", busy, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_en_n && !bus_clk && !bus_dout && bus_doe, "R1", "bus idle",
            {bus_en_n, bus_clk, bus_dout, bus_doe}, 4'b1001);
        chk(!busy && !done && rdata == 16'h0, "R1", "host idle",
            {busy, done, rdata}, 0);
        for (int a = 0; a < 128; a++) begin
            logic [6:0]  av;
            logic [15:0] wd;
            av = 7'(a);
            wd = (a % 3 == 0) ? 16'hFFFF : (a % 3 == 1) ? 16'h0000
                                          : {av, 2'b10, av ^ 7'h2A};
            xfer(1'b0, av, wd, 1'b0);
            slave_word = {~av, 2'b01, av};
            xfer(1'b1, av, 16'h0, 1'b0);
        end
        slave_word = 16'hA5C3;
        xfer(1'b0, 7'h33, 16'h1234, 1'b1);
        xfer(1'b1, 7'h4C, 16'h0, 1'b1);
        slave_word = 16'h0F0F;
        xfer(1'b0, 7'h7F, 16'h8001, 1'b0);
        chk(idle_clk == 0, "R7", "clock while deselected", idle_clk, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule